// File: doc/BRIEF.md
# ADC Result Offset Corrector

This block sits between an ADC conversion pipeline and the result storage. Each raw conversion result that arrives with a valid strobe is corrected by a signed calibration value before it leaves the block. Software measures the converter's offset and programs its negative as the calibration code. The corrected result then has the offset removed.

The calibration code is always counted in LSBs of a 12-bit conversion. At 10-bit or 8-bit resolution the code is scaled down to the matching weight. The sum never wraps. A result that would fall below zero, or rise above the full-scale code of the selected resolution, is clamped to that limit, and a saturation flag marks it. The output is registered, with one cycle of latency.

Top module: `adc_offset_corrector`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_sat` and `out_result` are all 0 until the first valid input has been registered.
- R2: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low.
- R3: With `res_sel` = 0 (12-bit), the result is `in_raw` plus `cal_code` read as 6-bit two's complement. Code 0x3D means −3 and code 0x1F means +31.
- R4: With `res_sel` = 1 (10-bit), the correction is `cal_code` arithmetically shifted right by 2 (floor division by 4). `in_raw[11:10]` are ignored, and the result occupies `out_result[9:0]` with the upper bits 0.
- R5: With `res_sel` = 2 (8-bit), the correction is `cal_code` arithmetically shifted right by 4. `in_raw[11:8]` are ignored, and the result occupies `out_result[7:0]` with the upper bits 0.
- R6: A sum below 0 gives a result of 0, with `out_sat` high.
- R7: A sum above 2^N−1 gives a result of 2^N−1 for the selected resolution N, with `out_sat` high.
- R8: `out_sat` is high only alongside a valid output that was clamped. It is low in every other cycle.
- R9: The correction uses the `cal_code` present in the same cycle as `in_valid`. A later change to `cal_code` does not alter a result already taken, and it applies to the results that follow.
- R10: While `in_valid` is low, `out_result` keeps its last value.
- R11: `res_sel` = 3 behaves exactly as 12-bit resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw result strobe |
| in_raw | input | 12 | Raw conversion result, right aligned |
| res_sel | input | 2 | Resolution: 0=12, 1=10, 2=8, 3=12 bits |
| cal_code | input | 6 | Signed offset correction in 12-bit LSBs |
| out_valid | output | 1 | Corrected result strobe |
| out_result | output | 12 | Corrected, clamped result, right aligned |
| out_sat | output | 1 | Result was clamped |

## Verification
Every corrected result, its valid strobe and its saturation flag are due exactly one clock edge after the input cycle that carried the raw value, because the only register on the path is the output stage. The bench drives each input on a falling edge. After the next rising edge, it compares against a behavioural model evaluated on those same inputs, sampling at the following falling edge. In cycles with no valid input, it expects the flag low and the result unchanged from the previous sample. A calibration change is exercised one cycle after a sample so that the one-cycle attribution is tested explicitly.

// File: rtl/adc_offset_corrector.sv
module adc_offset_corrector #(
  parameter int RAW_W = 12,
  parameter int CAL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RAW_W-1:0] in_raw,
  input  logic [1:0]       res_sel,
  input  logic [CAL_W-1:0] cal_code,
  output logic             out_valid,
  output logic [RAW_W-1:0] out_result,
  output logic             out_sat
);
  localparam int SUM_W = RAW_W + 2;

  logic [2:0]              shamt;
  logic [RAW_W-1:0]        full_scale;
  logic [RAW_W-1:0]        raw_m;
  logic signed [CAL_W-1:0] corr;
  logic signed [SUM_W-1:0] sum;
  logic                    under, over;

  always_comb begin
    case (res_sel)
      2'd1:    shamt = 3'd2;
      2'd2:    shamt = 3'd4;
      default: shamt = 3'd0;
    endcase
  end

  assign full_scale = {RAW_W{1'b1}} >> shamt;
  assign raw_m      = in_raw & full_scale;
  assign corr       = $signed(cal_code) >>> shamt;
  assign sum        = $signed({2'b00, raw_m}) + $signed({{(SUM_W-CAL_W){corr[CAL_W-1]}}, corr});
  assign under      = sum[SUM_W-1];
  assign over       = !under && (sum > $signed({2'b00, full_scale}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sat    <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_sat   <= in_valid && (under || over);
      if (in_valid) begin
        if (under)     out_result <= '0;
        else if (over) out_result <= full_scale;
        else           out_result <= sum[RAW_W-1:0];
      end
    end
  end
endmodule

module adc_offset_corrector_chk #(
  parameter int RAW_W = 12,
  parameter int CAL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [RAW_W-1:0] in_raw,
  input logic [1:0]       res_sel,
  input logic [CAL_W-1:0] cal_code,
  input logic             out_valid,
  input logic [RAW_W-1:0] out_result,
  input logic             out_sat
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  sat_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sat |-> out_valid);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  // R5
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && res_sel == 2'd2) |=> (out_result[RAW_W-1:8] == '0));
  // R3
  zero_cal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && res_sel == 2'd0 && cal_code == '0) |=> (out_result == $past(in_raw) && !out_sat));
endmodule

bind adc_offset_corrector adc_offset_corrector_chk #(.RAW_W(RAW_W), .CAL_W(CAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw), .res_sel(res_sel),
  .cal_code(cal_code), .out_valid(out_valid), .out_result(out_result), .out_sat(out_sat)
);

// File: tb/adc_offset_corrector_bench.sv
module adc_offset_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_raw = '0;
  logic [1:0]  res_sel = '0;
  logic [5:0]  cal_code = '0;
  logic        out_valid, out_sat;
  logic [11:0] out_result;

  int checks = 0, errors = 0;
  int prev_result = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_offset_corrector u_adc_offset_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw), .res_sel(res_sel),
    .cal_code(cal_code), .out_valid(out_valid), .out_result(out_result), .out_sat(out_sat)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void model(input int raw, input int rs, input int cal,
                                output int res, output int sat);
    int bits, fs, c, s;
    bits = (rs == 1) ? 10 : (rs == 2) ? 8 : 12;
    fs   = (1 << bits) - 1;
    c    = (cal >= 32) ? cal - 64 : cal;
    for (int k = 0; k < (12 - bits); k++)
      c = (c < 0) ? -((-c + 1) / 2) : c / 2;
    s = (raw % (1 << bits)) + c;
    if (s < 0) begin res = 0; sat = 1; end
    else if (s > fs) begin res = fs; sat = 1; end
    else begin res = s; sat = 0; end
  endfunction

  task automatic step(input bit v, input int raw, input int rs, input int cal, input string tag);
    int er, es;
    in_valid = v; in_raw = raw[11:0]; res_sel = rs[1:0]; cal_code = cal[5:0];
    model(raw, rs, cal, er, es);
    @(posedge clk);
    @(negedge clk);
    check({tag, "/R2 valid"}, int'(out_valid), int'(v));
    if (v) begin
      check({tag, " result"}, int'(out_result), er);
      check({tag, "/R8 sat"}, int'(out_sat), es);
      prev_result = er;
    end else begin
      check({tag, "/R10 hold"}, int'(out_result), prev_result);
      check({tag, "/R8 sat idle"}, int'(out_sat), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(out_valid), 0);
    check("R1 sat", int'(out_sat), 0);
    check("R1 result", int'(out_result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(out_result), 0);

    step(1, 1000, 0, 'h3D, "R3 minus3");
    step(1, 1000, 0, 'h1F, "R3 plus31");
    step(1, 1000, 0, 'h20, "R3 minus32");
    step(1, 12'hC00 | 500, 1, 'h3D, "R4 minus3 floor");
    step(1, 500, 1, 'h1F, "R4 plus31");
    step(1, 12'hF00 | 100, 2, 'h3D, "R5 minus3 floor");
    step(1, 100, 2, 'h1F, "R5 plus31");
    step(1, 100, 2, 'h03, "R5 small");
    step(1, 2, 0, 'h3D, "R6 low 12");
    step(1, 0, 2, 'h20, "R6 low 8");
    step(1, 4090, 0, 'h1F, "R7 high 12");
    step(1, 1022, 1, 'h1F, "R7 high 10");
    step(1, 255, 2, 'h10, "R7 high 8");
    step(0, 7, 0, 0, "R10 idle");
    step(1, 1000, 3, 'h3D, "R11 sel3");
    step(1, 300, 0, 'h3D, "R9 first");
    step(0, 300, 0, 'h1F, "R9 change idle");
    step(1, 300, 0, 'h1F, "R9 new code");
    step(1, 300, 0, 'h00, "R3 zero");
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 4096, $urandom % 4, $urandom % 64, "R3 random");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule